// File: doc/BRIEF.md
# Serial Pointer Packet Encoder

This block converts one relative pointer movement, given as signed horizontal and vertical deltas plus three button levels, into a five-byte serial pointer packet. The bytes go into a small circular byte queue. A host-side reader pops that queue one byte per read strobe. A receive-available flag tells the reader whether the queue holds anything.

A movement is offered with a one-cycle strobe. The deltas and buttons are captured on that edge. The five bytes are then pushed on the next five consecutive cycles. The reader sees each popped byte on a registered data output. A clear input discards everything queued and abandons any packet still being pushed.

Top module: `mouse_pkt_enc`

## Requirements
- R1: An accepted motion strobe makes the block push five bytes, one per cycle, on the five clock edges after the edge that sampled the strobe. The bytes go in this order: header, X, Y, 0x00, 0x00.
- R2: The header is 0x87 with bit 2 cleared while left is pressed, bit 1 cleared while middle is pressed, and bit 0 cleared while right is pressed (buttons sampled with the strobe).
- R3: The X byte is dx limited to the range -127..+127, in 8-bit two's complement. For example, 300 gives 0x7F and -512 gives 0x81.
- R4: The Y byte is -dy limited to the range -127..+127, in 8-bit two's complement. For example, dy=3 gives 0xFD and dy=-512 gives 0x7F.
- R5: The queue holds DEPTH bytes (default 16). A byte pushed while it is full is discarded and the held contents do not change.
- R6: A read strobe on an empty queue puts 0x00 on rxData.
- R7: rxAvail rises with every push. After a pop it stays high while bytes remain, and it drops when the queue empties.
- R8: A clear empties the queue, drops rxAvail and abandons a packet in progress.
- R9: A motion strobe that arrives while a packet is still being pushed is ignored.
- R10: Bytes come out in the order they were pushed, across read and write pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| moveStb | input | 1 | One-cycle strobe offering a movement |
| dx | input | DELTA_W | Signed horizontal delta |
| dy | input | DELTA_W | Signed vertical delta |
| btnLeft | input | 1 | Left button pressed |
| btnMid | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| clear | input | 1 | Empty the queue |
| readStb | input | 1 | Pop one byte |
| rxData | output | 8 | Last popped byte |
| rxAvail | output | 1 | Queue not empty |

## Verification
A strobe sampled on edge E has its five pushes on edges E+1 through E+5. The bench therefore waits five full cycles after dropping the strobe before it reads or checks rxAvail. A popped byte is registered on the edge that samples readStb, so the bench raises readStb at a falling edge and compares rxData at the next falling edge. The expected bytes are built from the requirements and placed in a scoreboard queue that models the depth limit. Each read compares the design's output against the front of that queue, or against 0x00 when the queue is empty.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_BYTES = 5;
  localparam logic [7:0] HDR_BASE = 8'h87;

  typedef struct packed {
    logic       load;  // capture deltas and buttons
    logic       push;  // push the byte picked by slot
    logic [2:0] slot;  // 0 header, 1 X, 2 Y, 3..4 padding
  } seqCmd_t;
endpackage

// File: rtl/mpe_seq.sv
module mpe_seq
  import mpe_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clear,
  input  logic    moveStb,
  output seqCmd_t cmd,
  output logic    busy
);
  localparam logic [2:0] LAST_SLOT = 3'(PKT_BYTES - 1);

  logic [2:0] slot;

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (!busy) begin
      if (moveStb) begin
        busy <= 1'b1;
        slot <= '0;
      end
    end else if (slot == LAST_SLOT) begin
      busy <= 1'b0;
      slot <= '0;
    end else begin
      slot <= slot + 3'd1;
    end
  end

  always_comb begin
    cmd.load = !busy && moveStb && !clear;
    cmd.push = busy && !clear;
    cmd.slot = slot;
  end

  // R1: the last slot ends the packet
  a_r1_packet_ends: assert property (@(posedge clk) disable iff (!rstN)
    (busy && slot == LAST_SLOT && !clear) |=> !busy);
  // R9: a strobe while busy does not restart the slot count
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (busy && moveStb && slot != LAST_SLOT && !clear) |=> (busy && slot != 3'd0));
endmodule

// File: rtl/mpe_path.sv
module mpe_path
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmd_t            cmd,
  input  logic [DELTA_W-1:0] dx,
  input  logic [DELTA_W-1:0] dy,
  input  logic [2:0]         btns,   // {left, middle, right}
  input  logic               clear,
  input  logic               popStb,
  output logic [7:0]         rxData,
  output logic               rxAvail
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic signed [DELTA_W:0] POS_LIM = (DELTA_W+1)'(127);
  localparam logic signed [DELTA_W:0] NEG_LIM = -(DELTA_W+1)'(127);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  function automatic logic [7:0] clampByte(input logic signed [DELTA_W:0] v);
    if (v > POS_LIM)      return 8'h7F;
    else if (v < NEG_LIM) return 8'h81;
    else                  return v[7:0];
  endfunction

  logic [7:0] pktHdr, pktX, pktY, pushByte;
  logic [7:0] fifoMem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic pushOk, popOk;
  logic signed [DELTA_W:0] dxWide, dyNeg;

  always_comb begin
    dxWide = $signed({dx[DELTA_W-1], dx});
    dyNeg  = -$signed({dy[DELTA_W-1], dy});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktHdr <= HDR_BASE;
      pktX   <= '0;
      pktY   <= '0;
    end else if (cmd.load) begin
      pktHdr <= HDR_BASE & ~{5'b0, btns};
      pktX   <= clampByte(dxWide);
      pktY   <= clampByte(dyNeg);
    end
  end

  always_comb begin
    case (cmd.slot)
      3'd0:    pushByte = pktHdr;
      3'd1:    pushByte = pktX;
      3'd2:    pushByte = pktY;
      default: pushByte = 8'h00;
    endcase
  end

  assign pushOk = cmd.push && (count < FULL_CNT);
  assign popOk  = popStb && (count != '0);

  always_ff @(posedge clk) begin
    if (pushOk) fifoMem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      count   <= '0;
      rxAvail <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(pushOk) - CW'(popOk);
      if (cmd.push)  rxAvail <= 1'b1;
      else if (popOk) rxAvail <= (count > CW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       rxData <= '0;
    else if (popStb) rxData <= popOk ? fifoMem[rdPtr] : 8'h00;
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  a_r5_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_CNT && !popStb && !clear) |=> count == FULL_CNT);
  a_r6_empty_pop_zero: assert property (@(posedge clk) disable iff (!rstN)
    (popStb && count == '0 && !clear) |=> rxData == 8'h00);
  a_r7_avail_tracks: assert property (@(posedge clk) disable iff (!rstN)
    rxAvail == (count != '0));
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0 && !rxAvail));
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               moveStb,
  input  logic [DELTA_W-1:0] dx,
  input  logic [DELTA_W-1:0] dy,
  input  logic               btnLeft,
  input  logic               btnMid,
  input  logic               btnRight,
  input  logic               clear,
  input  logic               readStb,
  output logic [7:0]         rxData,
  output logic               rxAvail
);
  seqCmd_t seqCmd;
  logic    seqBusy;

  mpe_seq i_seq (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (clear),
    .moveStb (moveStb),
    .cmd     (seqCmd),
    .busy    (seqBusy)
  );

  mpe_path #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) i_path (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (seqCmd),
    .dx      (dx),
    .dy      (dy),
    .btns    ({btnLeft, btnMid, btnRight}),
    .clear   (clear),
    .popStb  (readStb),
    .rxData  (rxData),
    .rxAvail (rxAvail)
  );

  // R1: pushing only follows an accepted strobe
  a_r1_push_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (seqCmd.load) |=> (seqBusy || clear));
endmodule

// File: tb/test_mouse_pkt_enc.sv
module test_mouse_pkt_enc;
  localparam int DW = 10;
  localparam int DEPTH = 16;

  logic clk = 0;
  logic rstN = 0;
  logic moveStb = 0;
  logic signed [DW-1:0] dx = 0, dy = 0;
  logic btnLeft = 0, btnMid = 0, btnRight = 0;
  logic clear = 0, readStb = 0;
  logic [7:0] rxData;
  logic rxAvail;

  int nChecks = 0;
  int nFails = 0;
  byte unsigned sb[$];

  always #5 clk = ~clk;

  mouse_pkt_enc #(.DELTA_W(DW), .DEPTH(DEPTH)) i_mouse_pkt_enc (
    .clk(clk), .rstN(rstN), .moveStb(moveStb), .dx(dx), .dy(dy),
    .btnLeft(btnLeft), .btnMid(btnMid), .btnRight(btnRight),
    .clear(clear), .readStb(readStb), .rxData(rxData), .rxAvail(rxAvail));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic byte unsigned clampByte(input int v);
    int c;
    c = (v > 127) ? 127 : (v < -127) ? -127 : v;
    return byte'(c & 8'hFF);
  endfunction

  task automatic sbPush(input byte unsigned b);
    if (sb.size() < DEPTH) sb.push_back(b);
  endtask

  // driver: strobe one movement and queue the expected bytes
  task automatic sendMove(input int mx, input int my, input bit l, input bit m, input bit r);
    byte unsigned hdr;
    @(negedge clk);
    dx = DW'(mx); dy = DW'(my);
    btnLeft = l; btnMid = m; btnRight = r; moveStb = 1;
    @(negedge clk);
    moveStb = 0;
    hdr = 8'h87 & ~{5'b0, l, m, r};
    sbPush(hdr);
    sbPush(clampByte(mx));
    sbPush(clampByte(-my));
    sbPush(8'h00);
    sbPush(8'h00);
    repeat (5) @(negedge clk);
  endtask

  // monitor: pop one byte and compare with the scoreboard front
  task automatic popCheck(input string tag);
    int exp;
    @(negedge clk);
    readStb = 1;
    @(negedge clk);
    readStb = 0;
    exp = (sb.size() > 0) ? int'(sb.pop_front()) : 0;
    check(tag, int'(rxData), exp);
  endtask

  task automatic drain(input string tag);
    while (sb.size() > 0) popCheck(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R7 reset rxAvail", int'(rxAvail), 0);
    popCheck("R6 pop after reset");
    check("R6 rxAvail after empty pop", int'(rxAvail), 0);

    // R1 R3 R4: no buttons, small motion
    sendMove(5, 3, 0, 0, 0);
    check("R7 avail after push", int'(rxAvail), 1);
    for (int i = 0; i < 4; i++) begin
      popCheck("R1 packet order");
      check("R7 avail while bytes remain", int'(rxAvail), 1);
    end
    popCheck("R1 last pad byte");
    check("R7 avail drops when empty", int'(rxAvail), 0);

    // R2 R3 R4: all buttons, positive saturation both ways
    sendMove(300, -300, 1, 1, 1);
    drain("R2 R3 R4 all buttons saturate");
    sendMove(-200, 200, 1, 0, 0);
    drain("R2 R3 R4 left only negative clamp");
    sendMove(-512, -512, 0, 1, 0);
    drain("R3 R4 extreme values middle");
    sendMove(127, 127, 0, 0, 1);
    drain("R3 R4 limit values right");
    sendMove(128, -128, 0, 0, 0);
    drain("R3 R4 one past limit");
    popCheck("R6 empty pop returns zero");

    // R9: second strobe while the packet is being pushed
    @(negedge clk);
    dx = 10; dy = 0; moveStb = 1;
    @(negedge clk);
    dx = 99; dy = 99; btnLeft = 1;
    @(negedge clk);
    moveStb = 0; btnLeft = 0;
    sbPush(8'h87); sbPush(8'd10); sbPush(8'h00); sbPush(8'h00); sbPush(8'h00);
    repeat (6) @(negedge clk);
    drain("R9 strobe while busy ignored");
    popCheck("R9 no extra packet");
    check("R9 queue empty after", int'(rxAvail), 0);

    // R5 R10: overflow and wrap-around
    for (int k = 0; k < 4; k++) sendMove(k + 1, -(k + 1), k[0], 0, k[1]);
    check("R5 queue holds depth", sb.size(), DEPTH);
    drain("R5 R10 overflow and wrap order");
    popCheck("R5 nothing beyond depth");
    check("R7 empty after drain", int'(rxAvail), 0);

    // R8: clear empties the queue
    sendMove(7, 7, 0, 0, 0);
    @(negedge clk);
    clear = 1;
    @(negedge clk);
    clear = 0;
    sb.delete();
    check("R8 avail after clear", int'(rxAvail), 0);
    popCheck("R8 pop after clear");
    sendMove(-3, -4, 0, 1, 1);
    drain("R8 R10 queue usable after clear");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule